// File: doc/BRIEF.md
# HDLC Test Control and Loopback Router

This block holds the 8-bit test and control word of an HDLC controller and steers data between the microprocessor FIFO port, the receive FIFO, the transmit FIFO and the serial bit streams. It sits between the FIFOs, the framer and the processor bus. It does not contain the FIFOs, the framer, the CRC logic or the address logic.

The control word carries a sticky software reset, two loopbacks and a FIFO test mode. The first loopback sends each received byte with its tag to both FIFOs. The second sends the serial transmit stream to the receive input. The FIFO test mode swaps the processor's FIFO access directions, so that the status logic of each FIFO can be exercised from the bus. Software writes the control word through a plain write strobe and can read it back at any time.

Top module: `hdlc_test_router`

## Requirements
- R1: After a synchronous active-low hardware reset, `reg_rdata` reads 0x00 and `soft_rst` is low.
- R2: A register write with bit 7 set makes `soft_rst` high from the next cycle. A single following write with bit 7 clear leaves it high.
- R3: A second register write with bit 7 clear, with no write between the two that has bit 7 set, clears bit 7 and `soft_rst`. Cycles without a write between the two zero writes do not matter.
- R4: A write with bit 7 set that falls between two zero writes restarts the sequence, so two further zero writes are needed to clear the bit.
- R5: Register bits are: 7 soft reset, 6 receive-to-transmit byte loopback, 3 CRC test, 2 FIFO test, 1 address test, 0 serial transmit-to-receive loopback. Bits 5 and 4 always read zero. All other bits read back the last value written, from the cycle after the write.
- R6: Each cycle with `rcv_valid` high writes `rcv_byte` and `rcv_tag` to the receive FIFO. When bit 6 is set, the same byte and tag are also written to the transmit FIFO, whatever the tag value (good or bad packet).
- R7: A received byte takes precedence over a processor write that would reach the same FIFO in the same cycle. That processor write is dropped.
- R8: With bit 2 clear, a processor transmit write goes to the transmit FIFO with its data and tag. A processor receive read strobes the receive FIFO and returns its data and tag.
- R9: With bit 2 set, a processor transmit write (data and tag) goes to the receive FIFO, and the transmit FIFO is not written by it.
- R10: With bit 2 set, a processor receive read strobes the transmit FIFO instead of the receive FIFO and returns the transmit FIFO's output data and tag.
- R11: `ser_rx_out` equals `ser_tx_in` when bit 0, `rx_en` and `tx_en` are all set. Otherwise it equals `line_rx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register current value |
| soft_rst | output | 1 | Sticky software reset to the HDLC |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| cpu_tx_wr | input | 1 | Processor transmit FIFO write strobe |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_wtag | input | TAG_W | Processor write tag bits |
| cpu_rx_rd | input | 1 | Processor receive FIFO read strobe |
| cpu_rdata | output | DATA_W | Data returned to processor |
| cpu_rtag | output | TAG_W | Tag bits returned to processor |
| rcv_valid | input | 1 | Received byte strobe |
| rcv_byte | input | DATA_W | Received byte (flags and CRC removed) |
| rcv_tag | input | TAG_W | Received byte tag (end of packet and status) |
| txf_wr | output | 1 | Transmit FIFO write |
| txf_wdata | output | DATA_W | Transmit FIFO write data |
| txf_wtag | output | TAG_W | Transmit FIFO write tag |
| txf_rd | output | 1 | Transmit FIFO read |
| txf_rdata | input | DATA_W | Transmit FIFO output data |
| txf_rtag | input | TAG_W | Transmit FIFO output tag |
| rxf_wr | output | 1 | Receive FIFO write |
| rxf_wdata | output | DATA_W | Receive FIFO write data |
| rxf_wtag | output | TAG_W | Receive FIFO write tag |
| rxf_rd | output | 1 | Receive FIFO read |
| rxf_rdata | input | DATA_W | Receive FIFO output data |
| rxf_rtag | input | TAG_W | Receive FIFO output tag |
| ser_tx_in | input | 1 | Serial transmit bit from the transmitter |
| line_rx_in | input | 1 | Serial receive bit from the line |
| ser_rx_out | output | 1 | Serial bit to the receiver |

## Verification
The only internal state is the control word and the armed flag of the two-write clear. A wrong armed flag shows on `reg_rdata[7]` and `soft_rst` one cycle after the second zero write, or after a zero write that follows a one. This can happen long after the fault, so the bench mixes directed zero/one/zero orderings with random writes. A wrong mode bit shows in the same cycle on the FIFO strobes and data, or on `ser_rx_out`. The bench therefore compares every routed output in every cycle against a model of the control word kept by the bench.

// File: rtl/hdlc_tr_pkg.sv
// Shared constants for the HDLC test control router: control bit
// positions (software decodes them) and the mask of writable bits.
package hdlc_tr_pkg;
    localparam int CTL_W      = 8;
    localparam int B_SRST     = 7;
    localparam int B_RTLOOP   = 6;
    localparam int B_CRCT     = 3;
    localparam int B_FTST     = 2;
    localparam int B_ARTST    = 1;
    localparam int B_TRLOOP   = 0;
    // Bits 5:4 are reserved and are never stored.
    localparam logic [CTL_W-1:0] WR_MASK = 8'hCF;
endpackage

// File: rtl/htr_ctl_reg.sv
// Control word register. Bit 7 is a sticky soft reset: a write of one sets
// it, and it clears only on the second write of zero with no write of one
// in between. Assumes one write per strobe cycle and a synchronous reset.
module htr_ctl_reg
    import hdlc_tr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             srst,
    output logic             rtloop,
    output logic             ftst,
    output logic             trloop
);
    localparam int LOW_W = CTL_W - 1;

    logic             srst_q;
    logic             armed_q;
    logic [LOW_W-1:0] low_q;

    // Store the writable low bits, with reserved bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_q <= '0;
        else if (wr)
            low_q <= wdata[LOW_W-1:0] & WR_MASK[LOW_W-1:0];
    end

    // Sticky reset bit and its two-zero-write clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (wr) begin
            if (wdata[B_SRST]) begin
                srst_q  <= 1'b1;
                armed_q <= 1'b0;
            end else if (srst_q && armed_q) begin
                srst_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (srst_q) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Present the current control value and decoded mode bits.
    always_comb begin
        rdata  = {srst_q, low_q};
        srst   = srst_q;
        rtloop = rdata[B_RTLOOP];
        ftst   = rdata[B_FTST];
        trloop = rdata[B_TRLOOP];
    end

    a_r2_single_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[B_SRST] && srst_q && !armed_q) |=> srst_q);
    a_r3_second_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[B_SRST] && armed_q) |=> !srst_q);
    a_r3_armed_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> srst_q);
    a_r4_one_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_SRST]) |=> (srst_q && !armed_q));
    a_r5_low_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata[B_FTST] == $past(wdata[B_FTST])));
endmodule

// File: rtl/htr_fifo_steer.sv
// FIFO access steering. Routes the received byte stream and the processor
// write/read strobes to the transmit and receive FIFOs according to the
// byte loopback and FIFO test modes. Purely combinational. A received byte
// wins over a processor write that targets the same FIFO in the same cycle.
module htr_fifo_steer #(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtloop,
    input  logic              ftst,
    input  logic              cpu_tx_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [TAG_W-1:0]  cpu_wtag,
    input  logic              cpu_rx_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [TAG_W-1:0]  cpu_rtag,
    input  logic              rcv_valid,
    input  logic [DATA_W-1:0] rcv_byte,
    input  logic [TAG_W-1:0]  rcv_tag,
    output logic              txf_wr,
    output logic [DATA_W-1:0] txf_wdata,
    output logic [TAG_W-1:0]  txf_wtag,
    output logic              txf_rd,
    input  logic [DATA_W-1:0] txf_rdata,
    input  logic [TAG_W-1:0]  txf_rtag,
    output logic              rxf_wr,
    output logic [DATA_W-1:0] rxf_wdata,
    output logic [TAG_W-1:0]  rxf_wtag,
    output logic              rxf_rd,
    input  logic [DATA_W-1:0] rxf_rdata,
    input  logic [TAG_W-1:0]  rxf_rtag
);
    logic loop_hit;
    logic cpu_to_tx;
    logic cpu_to_rx;

    // Decide which source owns each FIFO write port this cycle.
    always_comb begin
        loop_hit  = rtloop && rcv_valid;
        cpu_to_tx = cpu_tx_wr && !ftst && !loop_hit;
        cpu_to_rx = cpu_tx_wr && ftst && !rcv_valid;
    end

    // Transmit FIFO write port.
    always_comb begin
        txf_wr    = loop_hit || cpu_to_tx;
        txf_wdata = loop_hit ? rcv_byte : cpu_wdata;
        txf_wtag  = loop_hit ? rcv_tag  : cpu_wtag;
    end

    // Receive FIFO write port.
    always_comb begin
        rxf_wr    = rcv_valid || cpu_to_rx;
        rxf_wdata = rcv_valid ? rcv_byte : cpu_wdata;
        rxf_wtag  = rcv_valid ? rcv_tag  : cpu_wtag;
    end

    // Processor read side: test mode reads the transmit FIFO.
    always_comb begin
        rxf_rd    = cpu_rx_rd && !ftst;
        txf_rd    = cpu_rx_rd && ftst;
        cpu_rdata = ftst ? txf_rdata : rxf_rdata;
        cpu_rtag  = ftst ? txf_rtag  : rxf_rtag;
    end

    a_r6_rcv_to_both: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_valid && rtloop) |-> (txf_wr && rxf_wr && txf_wdata == rxf_wdata
                                   && txf_wtag == rxf_wtag));
    a_r7_rcv_owns_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_valid |-> (rxf_wdata == rcv_byte && rxf_wtag == rcv_tag));
    a_r9_test_no_cpu_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (ftst && !rcv_valid) |-> !txf_wr);
    a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({txf_rd, rxf_rd}));
endmodule

// File: rtl/htr_serial_loop.sv
// Serial loopback selector. Feeds the receiver with the transmit bit while
// the loopback bit and both direction enables are set, else with the line.
module htr_serial_loop (
    input  logic clk,
    input  logic rst_n,
    input  logic trloop,
    input  logic rx_en,
    input  logic tx_en,
    input  logic ser_tx_in,
    input  logic line_rx_in,
    output logic ser_rx_out
);
    logic loop_on;

    // Select the receive bit source.
    always_comb begin
        loop_on    = trloop && rx_en && tx_en;
        ser_rx_out = loop_on ? ser_tx_in : line_rx_in;
    end

    a_r11_line_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(trloop && rx_en && tx_en) |-> (ser_rx_out == line_rx_in));
endmodule

// File: rtl/hdlc_test_router.sv
// Top of the HDLC test control router: control register, FIFO steering and
// serial loopback. Assumes FIFOs and framer sit outside and accept one-cycle
// strobes. Synchronous active-low reset.
module hdlc_test_router
    import hdlc_tr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              soft_rst,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              cpu_tx_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [TAG_W-1:0]  cpu_wtag,
    input  logic              cpu_rx_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [TAG_W-1:0]  cpu_rtag,
    input  logic              rcv_valid,
    input  logic [DATA_W-1:0] rcv_byte,
    input  logic [TAG_W-1:0]  rcv_tag,
    output logic              txf_wr,
    output logic [DATA_W-1:0] txf_wdata,
    output logic [TAG_W-1:0]  txf_wtag,
    output logic              txf_rd,
    input  logic [DATA_W-1:0] txf_rdata,
    input  logic [TAG_W-1:0]  txf_rtag,
    output logic              rxf_wr,
    output logic [DATA_W-1:0] rxf_wdata,
    output logic [TAG_W-1:0]  rxf_wtag,
    output logic              rxf_rd,
    input  logic [DATA_W-1:0] rxf_rdata,
    input  logic [TAG_W-1:0]  rxf_rtag,
    input  logic              ser_tx_in,
    input  logic              line_rx_in,
    output logic              ser_rx_out
);
    logic rtloop;
    logic ftst;
    logic trloop;

    htr_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .srst(soft_rst), .rtloop(rtloop),
        .ftst(ftst), .trloop(trloop)
    );

    htr_fifo_steer #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .rtloop(rtloop), .ftst(ftst),
        .cpu_tx_wr(cpu_tx_wr), .cpu_wdata(cpu_wdata), .cpu_wtag(cpu_wtag),
        .cpu_rx_rd(cpu_rx_rd), .cpu_rdata(cpu_rdata), .cpu_rtag(cpu_rtag),
        .rcv_valid(rcv_valid), .rcv_byte(rcv_byte), .rcv_tag(rcv_tag),
        .txf_wr(txf_wr), .txf_wdata(txf_wdata), .txf_wtag(txf_wtag),
        .txf_rd(txf_rd), .txf_rdata(txf_rdata), .txf_rtag(txf_rtag),
        .rxf_wr(rxf_wr), .rxf_wdata(rxf_wdata), .rxf_wtag(rxf_wtag),
        .rxf_rd(rxf_rd), .rxf_rdata(rxf_rdata), .rxf_rtag(rxf_rtag)
    );

    htr_serial_loop u_ser (
        .clk(clk), .rst_n(rst_n), .trloop(trloop), .rx_en(rx_en),
        .tx_en(tx_en), .ser_tx_in(ser_tx_in), .line_rx_in(line_rx_in),
        .ser_rx_out(ser_rx_out)
    );
endmodule

// File: tb/hdlc_test_router_bench.sv
`timescale 1ns/1ps
module hdlc_test_router_bench;
    localparam int DW = 8;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic soft_rst;
    logic rx_en = 1'b0, tx_en = 1'b0;
    logic cpu_tx_wr = 1'b0, cpu_rx_rd = 1'b0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic [TW-1:0] cpu_wtag = '0, cpu_rtag;
    logic rcv_valid = 1'b0;
    logic [DW-1:0] rcv_byte = '0;
    logic [TW-1:0] rcv_tag = '0;
    logic txf_wr, txf_rd, rxf_wr, rxf_rd;
    logic [DW-1:0] txf_wdata, rxf_wdata;
    logic [TW-1:0] txf_wtag, rxf_wtag;
    logic [DW-1:0] txf_rdata = '0, rxf_rdata = '0;
    logic [TW-1:0] txf_rtag = '0, rxf_rtag = '0;
    logic ser_tx_in = 1'b0, line_rx_in = 1'b0;
    logic ser_rx_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_reg = '0;
    logic m_armed = 1'b0;

    always #4 clk = ~clk;

    hdlc_test_router #(.DATA_W(DW), .TAG_W(TW)) u_hdlc_test_router (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench model of the control word update on a write.
    function automatic logic [8:0] next_ctl(input logic [7:0] r, input logic a,
                                            input logic [7:0] w);
        logic [7:0] nr;
        logic na;
        nr = {r[7], w[6], 2'b00, w[3:0]};
        na = a;
        if (w[7]) begin nr[7] = 1'b1; na = 1'b0; end
        else if (r[7] && a) begin nr[7] = 1'b0; na = 1'b0; end
        else if (r[7]) na = 1'b1;
        return {na, nr};
    endfunction

    // Compare every routed output against the model for the present inputs.
    task automatic check_routes();
        logic lp, ft, ctx, crx;
        lp  = m_reg[6] && rcv_valid;
        ft  = m_reg[2];
        ctx = cpu_tx_wr && !ft && !lp;
        crx = cpu_tx_wr && ft && !rcv_valid;
        chk("R5 rdata", reg_rdata, m_reg);
        chk("R2 soft_rst", soft_rst, m_reg[7]);
        chk("R6/R7/R8 txf_wr", txf_wr, lp || ctx);
        if (lp) begin
            chk("R6 txf_wdata", txf_wdata, rcv_byte);
            chk("R6 txf_wtag", txf_wtag, rcv_tag);
        end else if (ctx) begin
            chk("R8 txf_wdata", txf_wdata, cpu_wdata);
            chk("R8 txf_wtag", txf_wtag, cpu_wtag);
        end
        chk("R6/R9 rxf_wr", rxf_wr, rcv_valid || crx);
        if (rcv_valid) begin
            chk("R7 rxf_wdata", rxf_wdata, rcv_byte);
            chk("R6 rxf_wtag", rxf_wtag, rcv_tag);
        end else if (crx) begin
            chk("R9 rxf_wdata", rxf_wdata, cpu_wdata);
            chk("R9 rxf_wtag", rxf_wtag, cpu_wtag);
        end
        chk("R8/R10 rxf_rd", rxf_rd, cpu_rx_rd && !ft);
        chk("R10 txf_rd", txf_rd, cpu_rx_rd && ft);
        chk("R8/R10 cpu_rdata", cpu_rdata, ft ? txf_rdata : rxf_rdata);
        chk("R8/R10 cpu_rtag", cpu_rtag, ft ? txf_rtag : rxf_rtag);
        chk("R11 ser_rx_out", ser_rx_out,
            (m_reg[0] && rx_en && tx_en) ? ser_tx_in : line_rx_in);
    endtask

    // One cycle: drive at negedge, check, then advance model past posedge.
    task automatic cycle();
        logic [8:0] nx;
        #1 check_routes();
        @(posedge clk);
        if (reg_wr) begin
            nx = next_ctl(m_reg, m_armed, reg_wdata);
            m_reg = nx[7:0];
            m_armed = nx[8];
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        cycle();
    endtask

    task automatic randomize_data();
        cpu_wdata = DW'($urandom); cpu_wtag = TW'($urandom);
        rcv_byte = DW'($urandom); rcv_tag = TW'($urandom);
        txf_rdata = DW'($urandom); txf_rtag = TW'($urandom);
        rxf_rdata = DW'($urandom); rxf_rtag = TW'($urandom);
        ser_tx_in = 1'($urandom); line_rx_in = 1'($urandom);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        // Dirty the register before reset so the reset check means something.
        rst_n = 1'b1;
        reg_wr = 1'b1; reg_wdata = 8'hC5;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_reg = '0; m_armed = 1'b0;
        chk("R1 reset rdata", reg_rdata, 8'h00);
        chk("R1 reset soft_rst", soft_rst, 1'b0);

        // R5: reserved bits read zero.
        wr_reg(8'h7F);
        chk("R5 reserved", reg_rdata, 8'h4F);
        wr_reg(8'h00);
        // R2/R3: set, one zero holds, idle cycle, second zero clears.
        wr_reg(8'h80);
        chk("R2 set", soft_rst, 1'b1);
        wr_reg(8'h00);
        chk("R2 one zero", soft_rst, 1'b1);
        cycle();
        wr_reg(8'h00);
        chk("R3 two zeros", soft_rst, 1'b0);
        // R4: zero, one, zero keeps it set; another zero clears.
        wr_reg(8'h80); wr_reg(8'h00); wr_reg(8'h80); wr_reg(8'h00);
        chk("R4 rearm", soft_rst, 1'b1);
        wr_reg(8'h00);
        chk("R4 final clear", soft_rst, 1'b0);

        // R6/R7 directed: byte loopback with a bad-packet tag and a clashing write.
        wr_reg(8'h40);
        rcv_valid = 1'b1; cpu_tx_wr = 1'b1; randomize_data(); rcv_tag = 2'b11;
        cycle();
        // R9/R10 directed: FIFO test mode.
        rcv_valid = 1'b0;
        wr_reg(8'h04);
        cpu_tx_wr = 1'b1; cpu_rx_rd = 1'b1; randomize_data();
        cycle();
        // R11 directed: loopback needs both enables.
        cpu_tx_wr = 1'b0; cpu_rx_rd = 1'b0;
        wr_reg(8'h01);
        rx_en = 1'b1; tx_en = 1'b0; ser_tx_in = 1'b1; line_rx_in = 1'b0;
        cycle();
        tx_en = 1'b1;
        cycle();

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            randomize_data();
            rcv_valid = 1'($urandom);
            cpu_tx_wr = 1'($urandom);
            cpu_rx_rd = 1'($urandom);
            rx_en = ($urandom % 4) != 0;
            tx_en = ($urandom % 4) != 0;
            if ($urandom % 3 == 0) begin
                reg_wr = 1'b1;
                reg_wdata = 8'($urandom) & 8'hFF;
                if ($urandom % 2 == 0) reg_wdata[7] = 1'b0;
            end
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule